// File: doc/BRIEF.md
# Receive Frame Buffer Read Port

This block sits between a receive engine and a host bus. The receive engine pushes 32-bit words of a frame into an internal circular buffer and, once the frame is complete, pulses a frame-done strobe. The host drains the buffer through a single data register. Each host read returns the word at the read pointer and then moves the pointer on by one location. There is no random addressing. Words leave strictly in the order they were written, and a word that has been read cannot be fetched again.

Reads are gated by a count of complete frames held in the buffer. When that count is zero, either because nothing has arrived or because a frame is still being written, the read still completes on the bus. The returned data is zero and the read pointer does not move. Every frame begins with a header word whose low bits give the number of payload words that follow. The block uses the header to find the last word of each frame and lowers the frame count when the host reads that word.

Top module: `rxf_read_port`

## Requirements
- R1: While reset is high at a clock edge, the frame count returns to zero and `rd_valid` is low after that edge. The read pointer also returns to zero.
- R2: A read request made when the frame count is zero completes with `rd_valid` high and `rd_data` equal to zero.
- R3: While words of an unfinished frame have been written but no frame-done pulse has arrived, reads are gated as in R2. The read pointer stays where it is, so after the frame-done pulse the first read returns that frame's header word.
- R4: A read request made when the frame count is non-zero returns the word at the read pointer, and the pointer moves on by one. Successive reads return the written words in write order, and no word is returned twice.
- R5: `rd_valid` is high for exactly one cycle, in the cycle after each clock edge at which `rd_req` is sampled high, and `rd_data` is valid in that same cycle.
- R6: Each `wr_frame_done` pulse raises the frame count by one, saturating at its maximum.
- R7: A header word's low log2(DEPTH) bits give N, the number of payload words that follow it. The frame count falls by one when the read that returns the frame's last word (header plus N words) is accepted.
- R8: If a frame-done pulse and the read of a frame's last word occur at the same clock edge, the frame count is unchanged.
- R9: Both pointers wrap from DEPTH-1 to zero. Data read across the wrap boundary comes out in write order.
- R10: A write attempted while the buffer holds DEPTH unread words is dropped and does not move the write pointer.
- R11: A frame whose header length field is zero consists of the header alone. Reading that header ends the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Receive engine word write strobe |
| wr_data | input | 32 | Word written into the buffer |
| wr_frame_done | input | 1 | One-cycle pulse marking the frame just written as complete |
| rd_req | input | 1 | Host read strobe for the data register |
| rd_valid | output | 1 | Read response strobe, one cycle after `rd_req` |
| rd_data | output | 32 | Read data: buffer word, or zero on a gated read |
| frame_count | output | log2(DEPTH)+1 | Number of complete frames not yet fully read |

## Verification
The bench builds the block with DEPTH set to 16, which makes the length field four bits wide. With that depth, a single 16-word frame fills the buffer completely, so a dropped extra write (R10) can be observed. The same depth carries both pointers across the wrap boundary (R9) after a handful of earlier frames. Zero-length frames, a frame-done pulse that lands on the same edge as a last-word read, and reads issued against a frame still being written all fall within a few dozen cycles at this size.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Position of the read pointer inside the current frame
    typedef enum logic {
        POS_HEAD = 1'b0,
        POS_BODY = 1'b1
    } frame_pos_e;

    // Registered host read response
    typedef struct packed {
        logic  valid;
        word_t data;
    } rd_resp_t;

    // True when the word being consumed closes its frame
    function automatic logic closes_frame(input frame_pos_e pos,
                                          input logic       hdr_len_zero,
                                          input logic       one_left);
        return (pos == POS_HEAD) ? hdr_len_zero : one_left;
    endfunction

endpackage

// File: rtl/rxf_mem.sv
module rxf_mem
    import rxf_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/rxf_ptr_ctrl.sv
module rxf_ptr_ctrl #(
    parameter int AW = 9
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_adv,
    output logic          wr_ok,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr
);

    // One extra bit separates full from empty
    logic [AW:0] wp_q;
    logic [AW:0] rp_q;
    logic        full;

    assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    assign wr_ok   = wr_en && !full;
    assign wr_addr = wp_q[AW-1:0];
    assign rd_addr = rp_q[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (wr_ok) begin
                wp_q <= wp_q + 1'b1;
            end
            if (rd_adv) begin
                rp_q <= rp_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxf_frame_trk.sv
module rxf_frame_trk
    import rxf_pkg::*;
#(
    parameter int AW = 9,
    localparam int CW = AW + 1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_done,
    input  logic          rd_adv,
    input  word_t         cur_word,
    output logic [CW-1:0] frame_cnt,
    output logic          last_rd
);

    frame_pos_e    pos_q;
    logic [AW-1:0] left_q;
    logic [AW-1:0] hdr_len;
    logic          inc;

    assign hdr_len = cur_word[AW-1:0];
    assign last_rd = rd_adv && closes_frame(pos_q, hdr_len == '0, left_q == AW'(1));
    assign inc     = frame_done && (frame_cnt != {CW{1'b1}});

    // Position inside the frame being drained
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= POS_HEAD;
            left_q <= '0;
        end else if (rd_adv) begin
            if (pos_q == POS_HEAD) begin
                if (hdr_len != '0) begin
                    pos_q  <= POS_BODY;
                    left_q <= hdr_len;
                end
            end else begin
                left_q <= left_q - 1'b1;
                if (left_q == AW'(1)) begin
                    pos_q <= POS_HEAD;
                end
            end
        end
    end

    // Complete frames held in the buffer
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= '0;
        end else begin
            case ({inc, last_rd})
                2'b10:   frame_cnt <= frame_cnt + 1'b1;
                2'b01:   frame_cnt <= frame_cnt - 1'b1;
                default: frame_cnt <= frame_cnt;
            endcase
        end
    end

endmodule

// File: rtl/rxf_read_port.sv
module rxf_read_port
    import rxf_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [31:0]   wr_data,
    input  logic          wr_frame_done,
    input  logic          rd_req,
    output logic          rd_valid,
    output logic [31:0]   rd_data,
    output logic [CW-1:0] frame_count
);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          wr_ok;
    logic          rd_adv;
    logic          last_rd;
    word_t         cur_word;
    rd_resp_t      resp_q;

    // A read only consumes a word when a whole frame is waiting
    assign rd_adv = rd_req && (frame_count != '0);

    rxf_ptr_ctrl #(.AW(AW)) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_adv  (rd_adv),
        .wr_ok   (wr_ok),
        .wr_addr (wr_ptr),
        .rd_addr (rd_ptr)
    );

    rxf_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (cur_word)
    );

    rxf_frame_trk #(.AW(AW)) u_trk (
        .clk        (clk),
        .rst        (rst),
        .frame_done (wr_frame_done),
        .rd_adv     (rd_adv),
        .cur_word   (cur_word),
        .frame_cnt  (frame_count),
        .last_rd    (last_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.valid <= rd_req;
            resp_q.data  <= rd_adv ? cur_word : '0;
        end
    end

    assign rd_valid = resp_q.valid;
    assign rd_data  = resp_q.data;

endmodule

// File: rtl/rxf_read_port_chk.sv
module rxf_read_port_chk #(
    parameter int AW = 9,
    localparam int CW = AW + 1
)(
    input logic          clk,
    input logic          rst,
    input logic          rd_req,
    input logic          wr_frame_done,
    input logic          rd_valid,
    input logic [31:0]   rd_data,
    input logic [CW-1:0] frame_count,
    input logic [AW-1:0] rd_ptr
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (frame_count == '0 && !rd_valid && rd_ptr == '0));

    assert_gated_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && frame_count == '0) |=> (rd_valid && rd_data == '0));

    assert_gated_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && frame_count == '0) |=> $stable(rd_ptr));

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && frame_count != '0) |=> (rd_ptr == AW'($past(rd_ptr) + 1'b1)));

    assert_no_req_no_move_R4: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(rd_ptr));

    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    assert_valid_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    assert_count_up_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_frame_done && !rd_req && frame_count != {CW{1'b1}})
        |=> (frame_count == CW'($past(frame_count) + 1'b1)));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_frame_done |=> (frame_count == $past(frame_count) ||
                            frame_count == CW'($past(frame_count) - 1'b1)));

    assert_idle_count_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_frame_done && !rd_req) |=> $stable(frame_count));

endmodule

bind rxf_read_port rxf_read_port_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rd_req        (rd_req),
    .wr_frame_done (wr_frame_done),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .frame_count   (frame_count),
    .rd_ptr        (rd_ptr)
);

// File: tb/rxf_read_port_tb.sv
module rxf_read_port_tb;

    localparam int  DEPTH      = 16;
    localparam int  CW         = $clog2(DEPTH) + 1;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          wr_frame_done = 1'b0;
    logic          rd_req = 1'b0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic [CW-1:0] frame_count;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    rxf_read_port #(.DEPTH(DEPTH)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .wr_frame_done (wr_frame_done),
        .rd_req        (rd_req),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .frame_count   (frame_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic put_word(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        wr_frame_done = 1'b1;
        @(negedge clk);
        wr_frame_done = 1'b0;
    endtask

    // One host read; response checked one edge later
    task automatic read_expect(input string tag, input logic [31:0] exp);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check({tag, " R5 valid"}, 32'(rd_valid), 32'd1);
        check(tag, rd_data, exp);
        @(negedge clk);
        check({tag, " R5 single"}, 32'(rd_valid), 32'd0);
    endtask

    task automatic check_count(input string tag, input int exp);
        check(tag, 32'(frame_count), 32'(exp));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_count("R1 count after reset", 0);
        check("R1 valid after reset", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_empty_read();
        read_expect("R2 empty read data", 32'h0);
        check_count("R2 count unchanged", 0);
    endtask

    task automatic t_partial_frame();
        put_word(32'h5A5A_0002);
        put_word(32'h1111_1111);
        put_word(32'h2222_2222);
        read_expect("R3 read during fill", 32'h0);
        check_count("R3 count still zero", 0);
        pulse_done();
        check_count("R6 count after done", 1);
        read_expect("R3 header after done", 32'h5A5A_0002);
        read_expect("R4 payload 1", 32'h1111_1111);
        check_count("R7 count before last", 1);
        read_expect("R4 payload 2", 32'h2222_2222);
        check_count("R7 count after last", 0);
        read_expect("R4 no reread", 32'h0);
    endtask

    task automatic t_two_frames();
        put_word(32'hA000_0001);
        put_word(32'hA1A1_A1A1);
        pulse_done();
        put_word(32'hB000_0002);
        put_word(32'hB1B1_B1B1);
        put_word(32'hB2B2_B2B2);
        pulse_done();
        check_count("R6 two frames", 2);
        read_expect("R4 frame A hdr", 32'hA000_0001);
        read_expect("R4 frame A word", 32'hA1A1_A1A1);
        check_count("R7 after frame A", 1);
        read_expect("R4 frame B hdr", 32'hB000_0002);
        read_expect("R4 frame B w1", 32'hB1B1_B1B1);
        read_expect("R4 frame B w2", 32'hB2B2_B2B2);
        check_count("R7 after frame B", 0);
    endtask

    task automatic t_zero_len();
        put_word(32'hABCD_0000);
        pulse_done();
        check_count("R11 count up", 1);
        read_expect("R11 header only", 32'hABCD_0000);
        check_count("R11 ended by header", 0);
    endtask

    task automatic t_simultaneous();
        put_word(32'hC000_0000);
        pulse_done();
        put_word(32'hD000_0001);
        put_word(32'hD1D1_D1D1);
        @(negedge clk);
        rd_req        = 1'b1;
        wr_frame_done = 1'b1;
        @(negedge clk);
        rd_req        = 1'b0;
        wr_frame_done = 1'b0;
        check("R8 last read data", rd_data, 32'hC000_0000);
        check_count("R8 count unchanged", 1);
        read_expect("R8 next frame hdr", 32'hD000_0001);
        read_expect("R8 next frame word", 32'hD1D1_D1D1);
        check_count("R8 drained", 0);
    endtask

    task automatic t_full_wrap();
        put_word(32'hE000_000F);
        for (int i = 1; i < DEPTH; i++) begin
            put_word(32'hE100_0000 + 32'(i));
        end
        put_word(32'hDEAD_BEEF);
        pulse_done();
        check_count("R10 one full frame", 1);
        read_expect("R9 hdr across wrap", 32'hE000_000F);
        for (int i = 1; i < DEPTH; i++) begin
            read_expect("R9 word across wrap", 32'hE100_0000 + 32'(i));
        end
        check_count("R9 full frame drained", 0);
        put_word(32'hF00D_0000);
        pulse_done();
        read_expect("R10 dropped write absent", 32'hF00D_0000);
        check_count("R10 drained", 0);
    endtask

    task automatic t_reset_mid();
        put_word(32'h7000_0001);
        put_word(32'h7777_7777);
        pulse_done();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_count("R1 count cleared mid run", 0);
        read_expect("R1 gated after reset", 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_empty_read();
        t_partial_frame();
        t_two_frames();
        t_zero_len();
        t_simultaneous();
        t_full_wrap();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule